// File: doc/BRIEF.md
# Pairwise-Order LRU Replacement Tracker

This block keeps the replacement state for a small, fully associative translation buffer of four entries. Recency is held as one ordering bit for each pair of entries. A bit at 1 means the higher-numbered entry of its pair was used more recently. When an entry is reported as used, the block forces every bit that pairs that entry with another one, so the entry becomes the most recent of the set. The other bits keep their values.

A decoder reads the stored bits and names the least recently used entry. That entry is the one the lookup logic replaces on a miss. Software can load the order bits directly and read them back. If a bit pattern names no single entry, it is flagged as invalid. Tag compare, translation and the buffer entries themselves sit outside this block.

Top module: `lru_pair_tracker`

## Requirements
- R1: In the cycle after a synchronous active-high reset, the order bits read back as 6'b000000, `victim_idx` is 3 and `state_invalid` is 0.
- R2: A use of entry 0 (`use_valid`=1, `use_idx`=0) clears order bits 5, 4 and 3 on the next clock edge. Bits 2..0 are kept.
- R3: A use of entry 1 sets bit 5 and clears bits 2 and 1. Bits 4, 3 and 0 are kept.
- R4: A use of entry 2 sets bits 4 and 2 and clears bit 0. Bits 5, 3 and 1 are kept.
- R5: A use of entry 3 sets bits 3, 1 and 0. Bits 5, 4 and 2 are kept.
- R6: `victim_idx` decodes the current bits as follows:
  - 0 when bits 5, 4 and 3 are all 1.
  - 1 when bit 5 is 0 and bits 2 and 1 are both 1.
  - 2 when bits 4 and 2 are 0 and bit 0 is 1.
  - 3 when bits 3, 1 and 0 are all 0.
  
  All other bits are don't-care for each pattern.
- R7: When the bits match none of the R6 patterns, `state_invalid` is 1 and `victim_idx` is 0. Otherwise `state_invalid` is 0.
- R8: With `sw_we`=1, the order bits take `sw_wdata` on the next edge, and `sw_rdata` shows them from then on.
- R9: When `sw_we` and `use_valid` are both 1 in the same cycle, the software value is loaded and the use is dropped.
- R10: With `use_valid`=0 and `sw_we`=0, the order bits do not change, whatever `use_idx` and `sw_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_valid | input | 1 | An entry was used this cycle |
| use_idx | input | 2 | Index of the used entry |
| sw_we | input | 1 | Software write strobe for the order bits |
| sw_wdata | input | 6 | Value loaded into the order bits |
| sw_rdata | output | 6 | Current order bits |
| victim_idx | output | 2 | Entry to replace on a miss |
| state_invalid | output | 1 | Order bits match no victim pattern |

## Verification
A software load and a hardware use update can arrive in the same cycle, and the two fight for the same six bits. The bench provokes this by presetting every one of the 64 order values. It then asserts `sw_we` together with `use_valid` for each of the four entries, with a write value that differs from the preset. The result is judged by reading the bits back one cycle later. They must equal the written value exactly, with no trace of the use masks.

// File: rtl/lru_pair_pkg.sv
package lru_pair_pkg;

  // Position of the ordering bit for entry pair (lo, hi), lo < hi.
  // Pairs are ranked lexicographically and placed from the top bit down.
  function automatic int unsigned pair_bit(input int unsigned ways,
                                           input int unsigned lo,
                                           input int unsigned hi);
    int unsigned rank;
    rank = 0;
    for (int unsigned a = 0; a < lo; a++) begin
      rank += ways - 1 - a;
    end
    rank += hi - lo - 1;
    return (ways * (ways - 1) / 2) - 1 - rank;
  endfunction

endpackage

// File: rtl/lru_pair_update.sv
module lru_pair_update #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned ORD_W = WAYS * (WAYS - 1) / 2
) (
  input  logic [ORD_W-1:0] order_cur,
  input  logic             touch_valid,
  input  logic [WAY_W-1:0] touch_idx,
  output logic [ORD_W-1:0] order_nxt
);

  // Each pair bit: set when its higher entry is touched, cleared when its lower one is.
  for (genvar lo = 0; lo < WAYS - 1; lo++) begin : g_lo
    for (genvar hi = lo + 1; hi < WAYS; hi++) begin : g_hi
      localparam int unsigned PB = lru_pair_pkg::pair_bit(WAYS, lo, hi);
      always_comb begin
        if (touch_valid && (touch_idx == WAY_W'(hi))) begin
          order_nxt[PB] = 1'b1;
        end else if (touch_valid && (touch_idx == WAY_W'(lo))) begin
          order_nxt[PB] = 1'b0;
        end else begin
          order_nxt[PB] = order_cur[PB];
        end
      end
    end
  end

endmodule

// File: rtl/lru_pair_decode.sv
module lru_pair_decode #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned ORD_W = WAYS * (WAYS - 1) / 2
) (
  input  logic [ORD_W-1:0] order_cur,
  output logic [WAY_W-1:0] victim,
  output logic             no_match
);

  logic [WAYS-1:0] oldest;

  // Entry k is oldest when every other entry is more recent than it.
  for (genvar k = 0; k < WAYS; k++) begin : g_way
    logic [WAYS-1:0] older_than;
    for (genvar m = 0; m < WAYS; m++) begin : g_peer
      if (m == k) begin : g_self
        assign older_than[m] = 1'b1;
      end else if (m > k) begin : g_up
        assign older_than[m] = order_cur[lru_pair_pkg::pair_bit(WAYS, k, m)];
      end else begin : g_dn
        assign older_than[m] = ~order_cur[lru_pair_pkg::pair_bit(WAYS, m, k)];
      end
    end
    assign oldest[k] = &older_than;
  end

  always_comb begin
    victim = '0;
    for (int k = 0; k < WAYS; k++) begin
      if (oldest[k]) begin
        victim = WAY_W'(k);
      end
    end
  end

  assign no_match = ~|oldest;

endmodule

// File: rtl/lru_pair_tracker.sv
module lru_pair_tracker #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned ORD_W = WAYS * (WAYS - 1) / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_valid,
  input  logic [WAY_W-1:0] use_idx,
  input  logic             sw_we,
  input  logic [ORD_W-1:0] sw_wdata,
  output logic [ORD_W-1:0] sw_rdata,
  output logic [WAY_W-1:0] victim_idx,
  output logic             state_invalid
);

  logic [ORD_W-1:0] order_q;
  logic [ORD_W-1:0] order_touched;

  lru_pair_update #(.WAYS(WAYS)) u_update (
    .order_cur   (order_q),
    .touch_valid (use_valid),
    .touch_idx   (use_idx),
    .order_nxt   (order_touched)
  );

  // Software load has priority over a hardware use in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= '0;
    end else if (sw_we) begin
      order_q <= sw_wdata;
    end else begin
      order_q <= order_touched;
    end
  end

  lru_pair_decode #(.WAYS(WAYS)) u_decode (
    .order_cur (order_q),
    .victim    (victim_idx),
    .no_match  (state_invalid)
  );

  assign sw_rdata = order_q;

endmodule

// File: rtl/lru_pair_tracker_chk.sv
module lru_pair_tracker_chk #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned ORD_W = WAYS * (WAYS - 1) / 2
) (
  input logic             clk,
  input logic             rst,
  input logic             use_valid,
  input logic [WAY_W-1:0] use_idx,
  input logic             sw_we,
  input logic [ORD_W-1:0] sw_wdata,
  input logic [ORD_W-1:0] sw_rdata,
  input logic [WAY_W-1:0] victim_idx,
  input logic             state_invalid
);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (sw_rdata == '0));

  a_r2_lowest_cleared: assert property (@(posedge clk) disable iff (rst)
    (use_valid && !sw_we && use_idx == '0) |=>
      (sw_rdata[ORD_W-1 -: WAYS-1] == '0) &&
      (sw_rdata[ORD_W-WAYS:0] == $past(sw_rdata[ORD_W-WAYS:0])));

  a_r5_last_not_victim: assert property (@(posedge clk) disable iff (rst)
    (use_valid && !sw_we && use_idx == WAY_W'(WAYS-1)) |=>
      !(victim_idx == WAY_W'(WAYS-1) && !state_invalid));

  a_r6_zero_all_newer: assert property (@(posedge clk) disable iff (rst)
    (!state_invalid && victim_idx == '0) |-> (&sw_rdata[ORD_W-1 -: WAYS-1]));

  a_r7_invalid_zero: assert property (@(posedge clk) disable iff (rst)
    state_invalid |-> (victim_idx == '0));

  a_r8_sw_load: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (sw_rdata == $past(sw_wdata)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !use_valid) |=> $stable(sw_rdata));

endmodule

bind lru_pair_tracker lru_pair_tracker_chk #(.WAYS(WAYS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .use_valid     (use_valid),
  .use_idx       (use_idx),
  .sw_we         (sw_we),
  .sw_wdata      (sw_wdata),
  .sw_rdata      (sw_rdata),
  .victim_idx    (victim_idx),
  .state_invalid (state_invalid)
);

// File: tb/lru_pair_tracker_tb.sv
module lru_pair_tracker_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       use_valid;
  logic [1:0] use_idx;
  logic       sw_we;
  logic [5:0] sw_wdata;
  logic [5:0] sw_rdata;
  logic [1:0] victim_idx;
  logic       state_invalid;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_pair_tracker u_dut (
    .clk           (clk),
    .rst           (rst),
    .use_valid     (use_valid),
    .use_idx       (use_idx),
    .sw_we         (sw_we),
    .sw_wdata      (sw_wdata),
    .sw_rdata      (sw_rdata),
    .victim_idx    (victim_idx),
    .state_invalid (state_invalid)
  );

  // Expected result of a use, from R2..R5.
  function automatic logic [5:0] exp_touch(input logic [5:0] s, input logic [1:0] i);
    logic [5:0] r;
    r = s;
    case (i)
      2'd0: begin r[5] = 0; r[4] = 0; r[3] = 0; end
      2'd1: begin r[5] = 1; r[2] = 0; r[1] = 0; end
      2'd2: begin r[4] = 1; r[2] = 1; r[0] = 0; end
      default: begin r[3] = 1; r[1] = 1; r[0] = 1; end
    endcase
    return r;
  endfunction

  // Expected {invalid, victim}, from R6 and R7.
  function automatic logic [2:0] exp_victim(input logic [5:0] s);
    if (s[5] && s[4] && s[3]) return 3'b0_00;
    if (!s[5] && s[2] && s[1]) return 3'b0_01;
    if (!s[4] && !s[2] && s[0]) return 3'b0_10;
    if (!s[3] && !s[1] && !s[0]) return 3'b0_11;
    return 3'b1_00;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic we, input logic [5:0] wd,
                      input logic uv, input logic [1:0] ui);
    sw_we = we; sw_wdata = wd; use_valid = uv; use_idx = ui;
    @(negedge clk);
    sw_we = 0; use_valid = 0;
  endtask

  initial begin
    rst = 1; use_valid = 0; use_idx = 0; sw_we = 0; sw_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    check("R1 rdata", int'(sw_rdata), 0);
    check("R1 victim", int'(victim_idx), 3);
    check("R1 invalid", int'(state_invalid), 0);

    // Touch all entries in order 0..3: entry 0 becomes oldest (R6), then entry 1.
    step(0, 6'h00, 1, 2'd0);
    step(0, 6'h00, 1, 2'd1);
    step(0, 6'h00, 1, 2'd2);
    step(0, 6'h00, 1, 2'd3);
    check("R6 order sweep state", int'(sw_rdata), 63);
    check("R6 order sweep victim", int'(victim_idx), 0);
    step(0, 6'h00, 1, 2'd0);
    check("R6 after reuse victim", int'(victim_idx), 1);

    // R8, R6, R7: every state via software load, decoded.
    for (int s = 0; s < 64; s++) begin
      logic [2:0] ev;
      step(1, 6'(s), 0, 2'd0);
      ev = exp_victim(6'(s));
      check("R8 load", int'(sw_rdata), s);
      check("R6 victim", int'(victim_idx), int'(ev[1:0]));
      check("R7 invalid", int'(state_invalid), int'(ev[2]));
    end

    // R2..R5: each use from each state.
    for (int s = 0; s < 64; s++) begin
      for (int i = 0; i < 4; i++) begin
        step(1, 6'(s), 0, 2'd0);
        step(0, ~6'(s), 1, 2'(i));
        case (i)
          0: check("R2 use0", int'(sw_rdata), int'(exp_touch(6'(s), 2'd0)));
          1: check("R3 use1", int'(sw_rdata), int'(exp_touch(6'(s), 2'd1)));
          2: check("R4 use2", int'(sw_rdata), int'(exp_touch(6'(s), 2'd2)));
          default: check("R5 use3", int'(sw_rdata), int'(exp_touch(6'(s), 2'd3)));
        endcase
      end
    end

    // R9: write and use together; R10: idle with busy side inputs.
    for (int s = 0; s < 64; s++) begin
      for (int i = 0; i < 4; i++) begin
        step(1, 6'(s), 0, 2'd0);
        step(1, 6'(s) ^ 6'h2a, 1, 2'(i));
        check("R9 write wins", int'(sw_rdata), s ^ 'h2a);
        step(1, 6'(s), 0, 2'd0);
        step(0, ~6'(s), 0, 2'(i));
        check("R10 idle hold", int'(sw_rdata), s);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule